// File: doc/BRIEF.md
# Dual-Phase 10:1 Serializer with Self-Test Source

The block turns a stream of 10-bit parallel words into a single serial bit stream. Each word is split into its even-numbered and odd-numbered bits. Each half goes into its own 5-bit parallel-load shift register that moves once per half-rate period. A final two-way selector alternates between the two registers, so each half-rate period sends two bits: the even bit first, then the odd bit. A source selector in front of the registers picks either the user word or a word from an internal pseudo-random self-test generator.

The model is fully synchronous. One bit-rate clock drives everything. A toggling phase flag stands in for the two phases of the half-rate clock. A counter of half-rate periods produces the word-rate load strobe. Upstream logic sees the strobe on `load_o` and must present the next word, and the source choice, in the cycle where the strobe is high. Inputs in all other cycles are ignored.

Top module: `dual_phase_serializer`

## Requirements
- R1: While `rst_n` is low at a rising edge, `ser_o` becomes 0. In the first cycle after reset is released, `load_o` is high, and the word captured at the end of that cycle is the first word sent, starting with its bit 0.
- R2: `load_o` is high for exactly one cycle in every 10, with nine low cycles between consecutive strobes.
- R3: The word captured at the rising edge that ends a cycle L with `load_o` high has its bit j on `ser_o` during cycle L+2+j, for j = 0..9. Bit 0 goes first, and in each pair the even bit comes before the odd bit.
- R4: Consecutive words leave with no gap. Bit 0 of a word follows directly after bit 9 of the previous word, and a lone set bit at position 0 or 9 lands in exactly one serial slot.
- R5: When `test_sel_i` is 1 in a load cycle, the word sent is the next 10 bits of a 7-bit self-test sequence. The state s starts at 7'h01 after reset. For each bit, b = s[6] XOR s[5], then s becomes {s[5:0], b}. The first b produced becomes word bit 0. In that cycle, `data_i` has no effect on the output.
- R6: The self-test sequence advances only on load cycles that select it. Data words sent in between do not consume self-test bits.
- R7: `data_i` and `test_sel_i` are sampled only in load cycles. Changing them in any other cycle has no effect on the serial output.
- R8: A reset in the middle of a word drops that word, drives `ser_o` to 0, and restarts both the word framing and the self-test sequence from its seed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_i | input | 10 | User word, sampled in load cycles |
| test_sel_i | input | 1 | 1 selects the self-test word, sampled in load cycles |
| load_o | output | 1 | Word-rate strobe marking the cycle in which the inputs are captured |
| ser_o | output | 1 | Serial output stream, bit 0 of each word first |

## Verification
A word captured in load cycle L produces its bit j on `ser_o` in cycle L+2+j. Its last bit is therefore due in cycle L+11, which is one cycle after the next strobe. The bench samples every output on the falling edge. For each word it sends, it records the expected value with a due cycle of L+11, and it shifts each sampled serial bit into a receive register. It compares the register only when the due cycle arrives, so two words in flight never mix. Strobe spacing is measured in the same falling-edge cycle count. The reset checks look at `ser_o` on the falling edge after the first reset edge.

// File: rtl/ser_pkg.sv
// Package: shared types and constants for the dual-phase serializer.
// Assumes: the self-test generator is a 7-bit LFSR, and the serial slot
// phase has exactly two values.
package ser_pkg;

    localparam int unsigned PRBS_W = 7;

    // Slot phase inside one half-rate period: even lane first, odd lane second.
    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } slot_phase_e;

endpackage

// File: rtl/ser_phase_ctrl.sv
// Module: ser_phase_ctrl
// Makes the half-rate phase flag and the word-rate load strobe from the
// single bit-rate clock. The phase toggles every cycle. A counter of
// half-rate periods wraps after HALF_W periods. The strobe is high in the
// odd slot of the last period of each word.
// Assumes: HALF_W >= 2. Reset leaves the controller in the strobe slot, so
// the first edge after reset loads a word.
module ser_phase_ctrl
    import ser_pkg::*;
#(
    parameter int unsigned HALF_W = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    output slot_phase_e phase_o,
    output logic        shift_en_o,
    output logic        load_o
);

    localparam int unsigned CNT_W = (HALF_W > 1) ? $clog2(HALF_W) : 1;
    localparam logic [CNT_W-1:0] LAST_PAIR = CNT_W'(HALF_W - 1);

    slot_phase_e      phase_q;
    logic [CNT_W-1:0] pair_q;

    // Toggle the slot phase and count pairs at the end of each odd slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_ODD;
            pair_q  <= LAST_PAIR;
        end else begin
            phase_q <= (phase_q == PH_EVEN) ? PH_ODD : PH_EVEN;
            if (phase_q == PH_ODD) begin
                pair_q <= (pair_q == LAST_PAIR) ? '0 : pair_q + 1'b1;
            end
        end
    end

    // Shift registers advance once per half-rate period, in the odd slot.
    always_comb begin
        phase_o    = phase_q;
        shift_en_o = (phase_q == PH_ODD);
        load_o     = (phase_q == PH_ODD) && (pair_q == LAST_PAIR);
    end

endmodule

// File: rtl/ser_half_sr.sv
// Module: ser_half_sr
// One half-rate lane: a parallel-load shift register in which each stage
// selects between its parallel bit and the stage above it. It moves only
// when shift_en is high. The LSB is the lane's next outgoing bit.
// Assumes: load is only high while shift_en is high, and W >= 2.
module ser_half_sr #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         load,
    input  logic [W-1:0] par_i,
    output logic         lsb_o
);

    logic [W-1:0] stage_q;

    // Per-stage 2:1 choice: parallel word on load, else the neighbour above.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (shift_en) begin
            if (load) begin
                stage_q <= par_i;
            end else begin
                stage_q <= {1'b0, stage_q[W-1:1]};
            end
        end
    end

    // Expose the stage that leaves next.
    assign lsb_o = stage_q[0];

endmodule

// File: rtl/ser_prbs_gen.sv
// Module: ser_prbs_gen
// Self-test word source: a 7-bit LFSR with taps for x^7 + x^6 + 1 that
// gives WORD_W fresh bits per word. Word bit 0 is the first bit generated.
// The state moves on only when the word is consumed.
// Assumes: SEED is non-zero.
module ser_prbs_gen
    import ser_pkg::*;
#(
    parameter int unsigned        WORD_W = 10,
    parameter logic [PRBS_W-1:0] SEED   = 7'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    output logic [WORD_W-1:0] word_o
);

    logic [PRBS_W-1:0] state_q;
    logic [PRBS_W-1:0] walk;
    logic              fb_bit;

    // Unroll WORD_W LFSR steps to form the word and the following state.
    always_comb begin
        walk   = state_q;
        fb_bit = 1'b0;
        word_o = '0;
        for (int i = 0; i < int'(WORD_W); i++) begin
            fb_bit    = walk[PRBS_W-1] ^ walk[PRBS_W-2];
            word_o[i] = fb_bit;
            walk      = {walk[PRBS_W-2:0], fb_bit};
        end
    end

    // Commit the stepped state only when a test word is loaded.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (advance) begin
            state_q <= walk;
        end
    end

endmodule

// File: rtl/dual_phase_serializer.sv
// Module: dual_phase_serializer (top)
// 10:1 serializer built from two half-rate lanes. The source mux picks the
// user word or the self-test word at the load strobe. The word is split into
// an even lane and an odd lane. A phase mux alternates between the lanes, and
// one output flop retimes the serial bit.
// Assumes: WORD_W is even. Inputs matter only in cycles where load_o is high.
module dual_phase_serializer
    import ser_pkg::*;
#(
    parameter int unsigned        WORD_W    = 10,
    parameter logic [PRBS_W-1:0] PRBS_SEED = 7'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] data_i,
    input  logic              test_sel_i,
    output logic              load_o,
    output logic              ser_o
);

    localparam int unsigned HALF_W = WORD_W / 2;
    localparam int unsigned LANES  = 2;

    slot_phase_e             phase;
    logic                    shift_en;
    logic [WORD_W-1:0]       prbs_word;
    logic [WORD_W-1:0]       src_word;
    logic [LANES-1:0][HALF_W-1:0] lane_par;
    logic [LANES-1:0]        lane_lsb;
    logic                    slot_bit;

    ser_phase_ctrl #(
        .HALF_W (HALF_W)
    ) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_o    (phase),
        .shift_en_o (shift_en),
        .load_o     (load_o)
    );

    ser_prbs_gen #(
        .WORD_W (WORD_W),
        .SEED   (PRBS_SEED)
    ) u_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (load_o && test_sel_i),
        .word_o  (prbs_word)
    );

    // Word mux: the source choice only matters in the load cycle.
    assign src_word = test_sel_i ? prbs_word : data_i;

    // Deal the word across the lanes and build one shift register per lane.
    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        for (genvar b = 0; b < HALF_W; b++) begin : g_bit
            assign lane_par[ln][b] = src_word[LANES*b + ln];
        end

        ser_half_sr #(
            .W (HALF_W)
        ) u_sr (
            .clk      (clk),
            .rst_n    (rst_n),
            .shift_en (shift_en),
            .load     (load_o),
            .par_i    (lane_par[ln]),
            .lsb_o    (lane_lsb[ln])
        );
    end

    // Phase mux: even lane in the first slot, odd lane in the second.
    assign slot_bit = (phase == PH_ODD) ? lane_lsb[1] : lane_lsb[0];

    // Output retiming flop, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ser_o <= 1'b0;
        end else begin
            ser_o <= slot_bit;
        end
    end

endmodule

// File: rtl/dual_phase_serializer_chk.sv
// Module: dual_phase_serializer_chk
// Property checker bound to the serializer top. It watches the strobe
// spacing, the first serial bits of each loaded word, and the self-test
// state hand-off.
// Assumes: it is attached by the bind below.
module dual_phase_serializer_chk #(
    parameter int unsigned WORD_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_o,
    input logic              ser_o,
    input logic              test_sel_i,
    input logic [WORD_W-1:0] src_word,
    input logic [WORD_W-1:0] prbs_word
);

    localparam int unsigned GAP_W = $clog2(WORD_W + 2) + 1;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    logic             after_rst;
    logic [GAP_W-1:0] gap_q;

    // Flags the first cycle after a reset edge.
    always_ff @(posedge clk) begin
        after_rst <= !rst_n;
    end

    // Counts the cycles since the last strobe, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (load_o) begin
            gap_q <= GAP_W'(1);
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R1
    first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        after_rst |-> (load_o && !ser_o));

    // R2
    load_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o == ((gap_q == '0) || (gap_q == GAP_W'(WORD_W))));

    // R2
    load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);

    // R3
    first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> ##2 (ser_o == $past(src_word[0], 2)));

    // R3
    second_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> ##3 (ser_o == $past(src_word[1], 3)));

    // R5
    prbs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && test_sel_i) |=> (prbs_word != $past(prbs_word)));

    // R6
    prbs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_o && test_sel_i) |=> $stable(prbs_word));

endmodule

bind dual_phase_serializer dual_phase_serializer_chk #(
    .WORD_W (WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_o     (load_o),
    .ser_o      (ser_o),
    .test_sel_i (test_sel_i),
    .src_word   (src_word),
    .prbs_word  (prbs_word)
);

// File: tb/dual_phase_serializer_tb.sv
// Bench: walks a table of words and sources through the serializer,
// deserializes ser_o on falling edges, and checks each word when its last
// bit is due. Directed reset tests follow the table.
module dual_phase_serializer_tb;

    localparam int unsigned WORD_W = 10;
    localparam int          NSTIM  = 10;
    localparam int          NPEND  = 4;
    localparam logic [6:0]  SEED   = 7'h01;

    // {test_sel, word}
    localparam logic [10:0] STIM [NSTIM] = '{
        11'h3FF, 11'h000, 11'h155, 11'h2AA, 11'h7A5,
        11'h4F0, 11'h001, 11'h200, 11'h555, 11'h1C3
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [WORD_W-1:0] data_i = '0;
    logic              test_sel_i = 1'b0;
    logic              load_o;
    logic              ser_o;

    int                checks = 0;
    int                fails  = 0;
    int                cyc    = 0;
    int                last_load = -1;
    bit                load_now = 1'b0;
    bit                done = 1'b0;
    logic [WORD_W-1:0] rx = '0;
    logic [6:0]        ref_s = SEED;
    logic [31:0]       lcg = 32'h1234_5678;
    int                pend_due [NPEND];
    logic [WORD_W-1:0] pend_exp [NPEND];
    bit                pend_v   [NPEND];
    string             pend_tag [NPEND];
    int                wr_idx = 0;

    dual_phase_serializer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_i     (data_i),
        .test_sel_i (test_sel_i),
        .load_o     (load_o),
        .ser_o      (ser_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Next word of the self-test sequence as R5 defines it.
    function automatic logic [WORD_W-1:0] ref_word();
        logic [WORD_W-1:0] w;
        logic b;
        for (int j = 0; j < int'(WORD_W); j++) begin
            b     = ref_s[6] ^ ref_s[5];
            w[j]  = b;
            ref_s = {ref_s[5:0], b};
        end
        return w;
    endfunction

    // One falling edge: shift the serial bit in and settle any word now due.
    task automatic tick();
        @(negedge clk);
        cyc++;
        rx = {ser_o, rx[WORD_W-1:1]};
        for (int k = 0; k < NPEND; k++) begin
            if (pend_v[k] && pend_due[k] == cyc) begin
                check(rx == pend_exp[k], pend_tag[k], rx, pend_exp[k]);
                pend_v[k] = 1'b0;
            end
        end
    endtask

    // Wait for the strobe, scrambling inputs until then (R7), and present a word.
    task automatic feed(input logic sel, input logic [WORD_W-1:0] w, input string tag);
        logic [WORD_W-1:0] exp;
        if (!load_now) begin
            while (1) begin
                tick();
                if (load_o) break;
                lcg        = lcg * 32'd1103515245 + 32'd12345;
                data_i     = lcg[25:16];
                test_sel_i = lcg[30];
            end
        end
        load_now = 1'b0;
        if (last_load >= 0)
            check(cyc - last_load == 10, "R2 strobe spacing", cyc - last_load, 10);
        last_load  = cyc;
        data_i     = w;
        test_sel_i = sel;
        exp        = sel ? ref_word() : w;
        pend_due[wr_idx] = cyc + 11;
        pend_exp[wr_idx] = exp;
        pend_v[wr_idx]   = 1'b1;
        pend_tag[wr_idx] = tag;
        wr_idx = (wr_idx + 1) % NPEND;
    endtask

    // Hold reset for three edges, check the output, then release in a load cycle.
    task automatic do_reset(input string tag);
        rst_n = 1'b0;
        for (int k = 0; k < NPEND; k++) pend_v[k] = 1'b0;
        for (int n = 0; n < 3; n++) begin
            tick();
            check(ser_o == 1'b0, {tag, " ser_o low in reset"}, ser_o, 0);
        end
        check(load_o == 1'b1, {tag, " strobe in first cycle"}, load_o, 1);
        rst_n     = 1'b1;
        ref_s     = SEED;
        last_load = -1;
        load_now  = 1'b1;
    endtask

    initial begin
        for (int k = 0; k < NPEND; k++) pend_v[k] = 1'b0;
        do_reset("R1");
        // Table walk: data patterns, self-test words, lone edge bits.
        for (int i = 0; i < NSTIM; i++) begin
            string tag;
            if (STIM[i][10])
                tag = (i == 8) ? "R6 sequence unmoved by data words" : "R5 self-test word";
            else
                tag = "R3/R4/R7 data word";
            feed(STIM[i][10], STIM[i][9:0], tag);
        end
        // Directed: reset part-way through a word.
        feed(1'b0, 10'h3C7, "R4 back-to-back word");
        repeat (4) tick();
        do_reset("R8");
        feed(1'b1, 10'h000, "R8 self-test restarts at seed");
        feed(1'b0, 10'h2D4, "R8 data after mid-word reset");
        feed(1'b1, 10'h3FF, "R5 second self-test after reset");
        repeat (14) tick();
        for (int k = 0; k < NPEND; k++)
            check(!pend_v[k], "R3 word never completed", pend_v[k], 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule